// File: doc/BRIEF.md
# 64B/66B Block Boundary Aligner

This block receives a continuous stream of 66-bit words recovered from a serial line and finds where the 66-bit blocks of a 64B/66B line code begin. Each block opens with a 2-bit sync field that must hold exactly one 1 and one 0. The field is not scrambled, so it stays DC-balanced by itself. The aligner keeps the previous input word, cuts a 66-bit window out of the current and previous words at a candidate bit offset, and tests the sync field of that window. While hunting, every bad sync field moves the candidate offset by one bit. After a long run of good fields it declares lock. From then on it delivers each aligned block with its header class and its 64-bit payload, which is still scrambled.

While locked, the block counts bad sync fields in fixed windows of blocks. It gives up lock when too many appear in one window and starts hunting again from the offset it held. Descrambling, the transceiver and any decoding of block contents belong to the neighbouring logic.

Top module: `blksync_aligner`

## Requirements
- R1: The sync field is window bits [1:0], with window bit 0 the earlier bit on the line. {bit1,bit0} = 2'b01 is a data header and 2'b10 is a control header. 2'b00 and 2'b11 are invalid. `out_hdr_type` is 1 exactly when the field is 2'b10, and `out_payload` equals window bits [65:2].
- R2: The window at offset k is bits [k+65:k] of {`in_data`, previous valid word}, with the previous word in the low half. After reset, the first valid word only fills the previous-word register and is not evaluated. A cycle with `in_valid` low changes neither the state nor the offset, and its output cycle has `out_valid` low.
- R3: While hunting, an evaluated block with an invalid header advances the offset by one, from 65 back to 0, and clears the count of good headers. The offset always lies in 0..65.
- R4: Lock is declared after LOCK_BLOCKS (default 64) consecutive evaluated blocks with valid headers at one offset. `out_lock` rises one clock after the last of them is presented.
- R5: While locked, invalid headers are counted within each run of WIN_BLOCKS (default 64) evaluated blocks, and the count is cleared when the run ends. The block whose error brings the count to ERR_LIMIT (default 16) drops lock. Hunting then resumes at the same offset with the counters cleared. The offset never changes while locked.
- R6: Outputs are registered one clock after the input word. `out_valid` is high only for a block evaluated while lock was already held, and `out_block` then holds that window.
- R7: A synchronous reset gives hunting at offset 0 with all counters cleared, `out_lock` low and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_data` carries a word this cycle |
| in_data | input | 66 | Received word, bit 0 earliest on the line |
| out_valid | output | 1 | Aligned block presented this cycle |
| out_block | output | 66 | Aligned 66-bit block |
| out_hdr_type | output | 1 | 0 for a data header, 1 for a control header |
| out_payload | output | 64 | Payload bits of the block, still scrambled |
| out_lock | output | 1 | Block boundary locked |

## Verification
The assertions take the input words to be consecutive slices of one continuous bit stream. A gap in `in_valid` must not drop bits. The window relation of R2 holds only under that condition. The stimulus builds every word from a single stream function with a fixed bit offset, inserts gaps without skipping any stream bits, and resets the block whenever the offset of the stream changes. Header errors are placed on chosen blocks of that same stream, so bursts, spread errors and runs that cross window boundaries all stay consistent with the stream the aligner sees.

// File: rtl/blksync_pkg.sv
package blksync_pkg;
  localparam int BLK_W = 66;
  localparam int HDR_W = 2;
  localparam int PAY_W = BLK_W - HDR_W;
  localparam int OFF_W = $clog2(BLK_W);

  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} sync_state_t;

  // legal sync fields carry exactly one 1 and one 0
  function automatic logic hdr_valid(input logic [HDR_W-1:0] h);
    return h[0] ^ h[1];
  endfunction

  function automatic logic hdr_ctrl(input logic [HDR_W-1:0] h);
    return h == 2'b10;
  endfunction

  // candidate offset steps through 0..BLK_W-1 and wraps
  function automatic logic [OFF_W-1:0] offset_next(input logic [OFF_W-1:0] o);
    return (o == OFF_W'(BLK_W - 1)) ? '0 : o + 1'b1;
  endfunction
endpackage

// File: rtl/blksync_window.sv
module blksync_window
  import blksync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_data,
  input  logic [OFF_W-1:0] off,
  output logic [BLK_W-1:0] win,
  output logic             win_ok
);
  localparam int CAT_W = 2 * BLK_W;

  logic [BLK_W-1:0] prev_q;
  logic             primed_q;
  logic [CAT_W-1:0] stage [OFF_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (in_valid) begin
      prev_q   <= in_data;
      primed_q <= 1'b1;
    end
  end

  // logarithmic barrel shifter, one stage per offset bit
  assign stage[0] = {in_data, prev_q};
  for (genvar s = 0; s < OFF_W; s++) begin : g_shift
    assign stage[s+1] = off[s] ? (stage[s] >> (2 ** s)) : stage[s];
  end

  assign win    = stage[OFF_W][BLK_W-1:0];
  assign win_ok = in_valid & primed_q;

  AST_PRIMED_BY_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(primed_q) |-> $past(in_valid)); // R2
endmodule

// File: rtl/blksync_hdr_check.sv
module blksync_hdr_check
  import blksync_pkg::*;
(
  input  logic [BLK_W-1:0] win,
  output logic             hdr_ok,
  output logic             hdr_is_ctrl,
  output logic [PAY_W-1:0] payload
);
  assign hdr_ok      = hdr_valid(win[HDR_W-1:0]);
  assign hdr_is_ctrl = hdr_ctrl(win[HDR_W-1:0]);
  assign payload     = win[BLK_W-1:HDR_W];
endmodule

// File: rtl/blksync_lock_fsm.sv
module blksync_lock_fsm
  import blksync_pkg::*;
#(
  parameter int LOCK_BLOCKS = 64,
  parameter int WIN_BLOCKS  = 64,
  parameter int ERR_LIMIT   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval,
  input  logic             hdr_ok,
  output logic [OFF_W-1:0] off,
  output logic             locked
);
  localparam int GOOD_W = $clog2(LOCK_BLOCKS + 1);
  localparam int BLKC_W = $clog2(WIN_BLOCKS + 1);
  localparam int ERR_W  = $clog2(ERR_LIMIT + 1);

  sync_state_t       state_q;
  logic [OFF_W-1:0]  off_q;
  logic [GOOD_W-1:0] good_q;
  logic [BLKC_W-1:0] blk_q;
  logic [ERR_W-1:0]  err_q;
  logic [ERR_W-1:0]  err_sum;

  // named internal events
  logic hunting, ev_slip, ev_lock, ev_drop, ev_win_end;

  assign hunting    = (state_q == ST_HUNT);
  assign err_sum    = err_q + {{(ERR_W-1){1'b0}}, ~hdr_ok};
  assign ev_slip    = hunting & eval & ~hdr_ok;
  assign ev_lock    = hunting & eval & hdr_ok & (good_q == GOOD_W'(LOCK_BLOCKS - 1));
  assign ev_drop    = ~hunting & eval & (err_sum >= ERR_W'(ERR_LIMIT));
  assign ev_win_end = ~hunting & eval & ~ev_drop & (blk_q == BLKC_W'(WIN_BLOCKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      off_q   <= '0;
      good_q  <= '0;
      blk_q   <= '0;
      err_q   <= '0;
    end else if (eval) begin
      if (hunting) begin
        if (ev_slip) begin
          off_q  <= offset_next(off_q);
          good_q <= '0;
        end else if (ev_lock) begin
          state_q <= ST_LOCK;
          good_q  <= '0;
          blk_q   <= '0;
          err_q   <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        if (ev_drop) begin
          state_q <= ST_HUNT;
          good_q  <= '0;
          blk_q   <= '0;
          err_q   <= '0;
        end else if (ev_win_end) begin
          blk_q <= '0;
          err_q <= '0;
        end else begin
          blk_q <= blk_q + 1'b1;
          err_q <= err_sum;
        end
      end
    end
  end

  assign off    = off_q;
  assign locked = (state_q == ST_LOCK);

  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    off_q <= OFF_W'(BLK_W - 1)); // R3
  AST_SLIP_STEP: assert property (@(posedge clk) disable iff (rst)
    ev_slip |=> (off_q == offset_next($past(off_q))) && (good_q == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(off_q) && $stable(state_q)); // R2
  AST_LOCK_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(good_q) == GOOD_W'(LOCK_BLOCKS - 1)); // R4
  AST_LOCK_OFF_FIXED: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(off_q)); // R5
  AST_DROP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(err_q) == ERR_W'(ERR_LIMIT - 1) && $stable(off_q)); // R5
endmodule

// File: rtl/blksync_aligner.sv
module blksync_aligner
  import blksync_pkg::*;
#(
  parameter int LOCK_BLOCKS = 64,
  parameter int WIN_BLOCKS  = 64,
  parameter int ERR_LIMIT   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_data,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_block,
  output logic             out_hdr_type,
  output logic [PAY_W-1:0] out_payload,
  output logic             out_lock
);
  logic [OFF_W-1:0] off;
  logic [BLK_W-1:0] win;
  logic             win_ok;
  logic             hdr_ok;
  logic             hdr_is_ctrl;
  logic [PAY_W-1:0] payload;
  logic             locked;

  blksync_window i_window (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .off      (off),
    .win      (win),
    .win_ok   (win_ok)
  );

  blksync_hdr_check i_hdr (
    .win         (win),
    .hdr_ok      (hdr_ok),
    .hdr_is_ctrl (hdr_is_ctrl),
    .payload     (payload)
  );

  blksync_lock_fsm #(
    .LOCK_BLOCKS (LOCK_BLOCKS),
    .WIN_BLOCKS  (WIN_BLOCKS),
    .ERR_LIMIT   (ERR_LIMIT)
  ) i_fsm (
    .clk    (clk),
    .rst    (rst),
    .eval   (win_ok),
    .hdr_ok (hdr_ok),
    .off    (off),
    .locked (locked)
  );

  logic deliver;
  assign deliver = win_ok & locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_block    <= '0;
      out_hdr_type <= 1'b0;
      out_payload  <= '0;
    end else begin
      out_valid <= deliver;
      if (deliver) begin
        out_block    <= win;
        out_hdr_type <= hdr_is_ctrl;
        out_payload  <= payload;
      end
    end
  end

  assign out_lock = locked;

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_lock)); // R6
  AST_VALID_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R6
  AST_PAYLOAD_SPLIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_payload == out_block[BLK_W-1:HDR_W]); // R1
endmodule

// File: tb/test_blksync_aligner.sv
module test_blksync_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 66;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [65:0] in_data = '0;
  logic        out_valid;
  logic [65:0] out_block;
  logic        out_hdr_type;
  logic [63:0] out_payload;
  logic        out_lock;

  blksync_aligner i_blksync_aligner (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_block(out_block), .out_hdr_type(out_hdr_type),
    .out_payload(out_payload), .out_lock(out_lock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // stream configuration
  int          s_off = 0;
  int unsigned c_lo = 0, c_hi = 0, c_step = 1;
  logic [1:0]  c_val = 2'b11;
  bit          gap_en = 0;
  bit          err_phase = 0;
  longint      w = 0;

  // reference model
  bit     m_primed, m_lock;
  int     m_off, m_good, m_blk, m_err;
  bit     e_valid, e_lock;
  logic [65:0] e_block;

  function automatic bit pay(int unsigned b, int unsigned p);
    int unsigned x;
    x = (b * 32'h9E3779B1) ^ (p * 32'h85EBCA6B + 32'h01234567);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 13);
    return x[7];
  endfunction

  function automatic logic [1:0] hdr_of(int unsigned b);
    if (b >= c_lo && b < c_hi && ((b - c_lo) % c_step) == 0) return c_val;
    return pay(b, 1) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic sbit(longint i);
    int unsigned b, p;
    logic [1:0] h;
    b = int'(i / NB);
    p = int'(i % NB);
    h = hdr_of(b);
    if (p < 2) return h[p];
    return pay(b, p);
  endfunction

  function automatic logic [65:0] slice(longint start);
    logic [65:0] r;
    for (int j = 0; j < NB; j++) r[j] = sbit(start + j);
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_primed = 0; m_lock = 0; m_off = 0; m_good = 0; m_blk = 0; m_err = 0;
    e_valid = 0; e_lock = 0; e_block = '0;
  endtask

  task automatic compare();
    string lt;
    lt = err_phase ? "R5" : (e_lock ? "R4" : "R3");
    check(out_lock == e_lock, lt, "out_lock", 66'(out_lock), 66'(e_lock));
    check(out_valid == e_valid, "R6", "out_valid", 66'(out_valid), 66'(e_valid));
    if (e_valid && out_valid) begin
      check(out_block == e_block, "R2", "out_block", out_block, e_block);
      check(out_hdr_type == (e_block[1:0] == 2'b10), "R1", "out_hdr_type",
            66'(out_hdr_type), 66'(e_block[1:0] == 2'b10));
      check(out_payload == e_block[65:2], "R1", "out_payload",
            66'(out_payload), 66'(e_block[65:2]));
    end
  endtask

  task automatic model_word();
    logic [65:0] blk;
    bit ok;
    int e2;
    if (!m_primed) begin
      m_primed = 1;
      e_valid = 0;
    end else begin
      blk = slice(NB * (w - 1) + s_off + m_off);
      ok = blk[0] ^ blk[1];
      e_valid = m_lock;
      if (e_valid) e_block = blk;
      if (!m_lock) begin
        if (!ok) begin
          m_off = (m_off == 65) ? 0 : m_off + 1;
          m_good = 0;
        end else if (m_good == 63) begin
          m_lock = 1; m_good = 0; m_blk = 0; m_err = 0;
        end else m_good++;
      end else begin
        e2 = m_err + (ok ? 0 : 1);
        if (e2 >= 16) begin
          m_lock = 0; m_good = 0; m_blk = 0; m_err = 0;
        end else if (m_blk == 63) begin
          m_blk = 0; m_err = 0;
        end else begin
          m_blk++; m_err = e2;
        end
      end
    end
    e_lock = m_lock;
  endtask

  task automatic step();
    bit v;
    @(negedge clk);
    compare();
    v = !(gap_en && (cyc % 9 == 4));
    in_valid = v;
    if (v) begin
      in_data = slice(NB * w + s_off);
      model_word();
      w++;
    end else begin
      in_data = {33{2'b11}};
      e_valid = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    check(out_lock == 0, "R7", "out_lock in reset", 66'(out_lock), 66'd0);
    check(out_valid == 0, "R7", "out_valid in reset", 66'(out_valid), 66'd0);
    rst = 0;
    model_reset();
    w = 0;
  endtask

  task automatic run_to_lock(int maxw);
    int n = 0;
    while (!m_lock && n < maxw) begin step(); n++; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R3 R4: sweep every stream bit offset, gaps on odd offsets (R2)
    for (int s = 0; s < NB; s++) begin
      s_off = s;
      gap_en = s[0];
      c_lo = 0; c_hi = 0;
      do_reset();
      run_to_lock(3000);
      run(2);
      check(out_lock == 1, "R4", "lock reached for stream offset", 66'(out_lock), 66'd1);
      run(30);
    end
    gap_en = 0;

    // R5: error bursts at stream offset 1 (aligned offset 65)
    s_off = 1;
    do_reset();
    run_to_lock(3000);
    run(10);
    err_phase = 1;
    c_step = 1; c_val = 2'b11;
    c_lo = int'(w) + 3; c_hi = c_lo + 15;
    run(90);
    check(out_lock == 1, "R5", "15 errors keep lock", 66'(out_lock), 66'd1);
    c_val = 2'b00;
    c_lo = int'(w) + 3; c_hi = c_lo + 20;
    run(25);
    check(out_lock == 0, "R5", "burst drops lock", 66'(out_lock), 66'd0);
    run_to_lock(4000);
    run(5);
    check(out_lock == 1, "R3", "relock after offset wrap", 66'(out_lock), 66'd1);

    // R5: spread errors across window boundaries
    c_step = 2; c_val = 2'b11;
    c_lo = int'(w) + 7; c_hi = c_lo + 32;
    run(60);
    c_step = 3;
    c_lo = int'(w) + 2; c_hi = c_lo + 60;
    gap_en = 1;
    run(200);
    run_to_lock(4000);
    run(20);
    gap_en = 0;
    err_phase = 0;

    // R7: reset while locked
    check(out_lock == 1, "R4", "locked before reset", 66'(out_lock), 66'd1);
    do_reset();
    run(3);
    check(out_lock == 0, "R7", "hunting after reset", 66'(out_lock), 66'd0);
    run_to_lock(3000);
    run(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule